// File: doc/BRIEF.md
# Output Fault Latch and Power-Good Monitor

This block supervises the output of a synchronous buck regulator from a sampled digital code of the output-sense voltage. It takes that code, a strobe marking each new sample, a soft-start-complete flag, a flag saying the low-side switch is conducting and the result of an overcurrent comparator. From these it chooses the override state handed to the gate drivers and drives an open-drain power-good line.

Three faults are watched, and each has its own arming condition. Undervolt is armed only once soft-start is over. Overvolt is armed from reset onward. Overcurrent counts only samples taken while the low side conducts. An undervolt or overcurrent trip turns both gates off. An overvolt trip turns the high side off and holds the low side on until the output has collapsed, and after that both gates are off. A fault must be present on two consecutive samples before it latches, and every latch holds until the next reset, which acts as power-on reset. Power-good uses separate entry and exit windows, so it has hysteresis. Losing power-good only changes the power-good line and leaves switching alone.

All thresholds are whole-number percentages of a reference code, held in parameters. The defaults are a 10-bit code with reference 512: undervolt below 384, overvolt above 640, collapse below 256, power-good entry 476..547, and power-good exit below 460 or above 563.

Top module: `out_fault_supervisor`

## Requirements
- R1: After reset, `gate_mode` is 2'b00 (run, no override) and `pg_drive_low` is 1 (line pulled low, not good).
- R2: With `ss_done`=1, two consecutive valid samples with `sense_code` < 384 set `gate_mode` to 2'b01 (both gates off). While `ss_done`=0, such samples have no effect.
- R3: A fault latches only when its condition is present on two consecutive valid samples. A single faulty sample, or two faulty samples with a clean sample between them, leaves `gate_mode` at 2'b00.
- R4: Two consecutive valid samples with `sense_code` > 640 set `gate_mode` to 2'b10 (high side off, low side forced on). This applies whether or not soft-start has finished.
- R5: While `gate_mode` is 2'b10, a valid sample with `sense_code` < 256 changes it to 2'b01, and it stays there even if the code rises again.
- R6: An overcurrent sample counts only when `ls_on`=1 and `oc_flag`=1. Two consecutive valid samples of that kind set `gate_mode` to 2'b01. A sample taken with `ls_on`=0 breaks the sequence.
- R7: Once any fault has latched, later clean samples do not return `gate_mode` to 2'b00. Only reset clears it.
- R8: Overvolt has priority. If it trips together with overcurrent, or after undervolt has already latched, `gate_mode` becomes 2'b10.
- R9: With `ss_done`=1 and no fault, a valid sample in 476..547 releases `pg_drive_low` to 0 at the next clock edge.
- R10: Once good, power-good stays good for samples in 460..563. It is lost on a sample below 460 or above 563. After a loss, it returns only on a sample in 476..547.
- R11: Losing power-good leaves `gate_mode` at 2'b00.
- R12: `pg_drive_low` is 1 whenever `ss_done`=0 or any fault has latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, used as power-on reset |
| sense_code | input | 10 | Sampled output-sense code |
| sample_vld | input | 1 | Marks a new sample on `sense_code` |
| ss_done | input | 1 | Soft-start complete |
| ls_on | input | 1 | Low-side switch conducting |
| oc_flag | input | 1 | Overcurrent comparator result |
| gate_mode | output | 2 | 00 run, 01 both gates off, 10 low side forced on |
| pg_drive_low | output | 1 | 1 pulls the open-drain power-good line low |

## Verification
The bench first uses runs of undervolt codes with soft-start off and then on, to separate the arming condition from the threshold. It then uses single, interrupted and consecutive faulty samples to show the two-sample filter at work. Overcurrent is tried with the conducting flag low, high and alternating, to prove that only conducting samples count. Overvolt is raised before soft-start and then followed by a collapse, which separates the low-side-on state from the both-off state and shows that the release is final. A code walk through the edge bands (465, 455, 465, 480, 560, 570) tells the entry window apart from the exit window.

// File: rtl/fg_pkg.sv
// Shared types for the output fault supervisor.
package fg_pkg;
    typedef enum logic [1:0] {
        GM_RUN      = 2'b00,
        GM_BOTH_OFF = 2'b01,
        GM_LOW_ON   = 2'b10
    } gate_mode_e;

    localparam int FLT_UV    = 0;
    localparam int FLT_OV    = 1;
    localparam int FLT_OC    = 2;
    localparam int FLT_COUNT = 3;
endpackage

// File: rtl/fg_level_cmp.sv
// Threshold comparators. Turns the sense code and the status flags into
// raw per-sample fault conditions, a collapse flag and the power-good
// entry and exit conditions.
// Assumes every threshold derived from the percentages fits in CODE_W bits.
module fg_level_cmp
    import fg_pkg::*;
#(
    parameter int CODE_W        = 10,
    parameter int REF_CODE      = 512,
    parameter int UV_PCT        = 75,
    parameter int OV_PCT        = 125,
    parameter int COLLAPSE_PCT  = 50,
    parameter int PG_IN_LO_PCT  = 93,
    parameter int PG_IN_HI_PCT  = 107,
    parameter int PG_OUT_LO_PCT = 90,
    parameter int PG_OUT_HI_PCT = 110
) (
    input  logic [CODE_W-1:0]    sense_code,
    input  logic                 ss_done,
    input  logic                 ls_on,
    input  logic                 oc_flag,
    output logic [FLT_COUNT-1:0] raw,
    output logic                 collapse,
    output logic                 pg_enter,
    output logic                 pg_leave
);
    localparam logic [CODE_W-1:0] UV_TH     = CODE_W'((REF_CODE * UV_PCT) / 100);
    localparam logic [CODE_W-1:0] OV_TH     = CODE_W'((REF_CODE * OV_PCT) / 100);
    localparam logic [CODE_W-1:0] CLPS_TH   = CODE_W'((REF_CODE * COLLAPSE_PCT) / 100);
    localparam logic [CODE_W-1:0] IN_LO_TH  = CODE_W'((REF_CODE * PG_IN_LO_PCT) / 100);
    localparam logic [CODE_W-1:0] IN_HI_TH  = CODE_W'((REF_CODE * PG_IN_HI_PCT) / 100);
    localparam logic [CODE_W-1:0] OUT_LO_TH = CODE_W'((REF_CODE * PG_OUT_LO_PCT) / 100);
    localparam logic [CODE_W-1:0] OUT_HI_TH = CODE_W'((REF_CODE * PG_OUT_HI_PCT) / 100);

    // Raw fault conditions, each with its own arming qualifier.
    always_comb begin
        raw         = '0;
        raw[FLT_UV] = ss_done && (sense_code < UV_TH);
        raw[FLT_OV] = sense_code > OV_TH;
        raw[FLT_OC] = ls_on && oc_flag;
    end

    // Collapse detection and the power-good window edges.
    always_comb begin
        collapse = sense_code < CLPS_TH;
        pg_enter = (sense_code >= IN_LO_TH) && (sense_code <= IN_HI_TH);
        pg_leave = (sense_code < OUT_LO_TH) || (sense_code > OUT_HI_TH);
    end
endmodule

// File: rtl/fg_trip_confirm.sv
// Confirms one fault. It latches after CONFIRM_N consecutive valid samples
// that show the raw condition, and holds until reset.
// Assumes CONFIRM_N >= 1. A clean valid sample restarts the count.
module fg_trip_confirm #(
    parameter int CONFIRM_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_vld,
    input  logic raw,
    output logic tripped
);
    localparam int               CNT_W = $clog2(CONFIRM_N + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CONFIRM_N - 1);

    logic [CNT_W-1:0] streak;

    // Counts the consecutive faulty samples and sets the sticky trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak  <= '0;
            tripped <= 1'b0;
        end else if (sample_vld) begin
            if (raw) begin
                if (streak == LAST) tripped <= 1'b1;
                else                streak  <= streak + 1'b1;
            end else begin
                streak <= '0;
            end
        end
    end

    // R3
    trip_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |-> $past(sample_vld && raw));

    // R7
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> tripped);
endmodule

// File: rtl/fg_pgood_win.sv
// Power-good state with hysteresis. It becomes good on an entry-window
// sample and is lost on an exit-window sample. It is cleared while
// soft-start is running or a fault is latched.
module fg_pgood_win (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_vld,
    input  logic ss_done,
    input  logic fault_any,
    input  logic enter,
    input  logic leave,
    output logic pg_ok
);
    // Tracks the good state on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !ss_done || fault_any) pg_ok <= 1'b0;
        else if (sample_vld && !pg_ok && enter) pg_ok <= 1'b1;
        else if (sample_vld && pg_ok && leave)  pg_ok <= 1'b0;
    end

    // R12
    pg_needs_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> !pg_ok);

    // R10
    pg_entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_ok) |-> $past(sample_vld && enter));
endmodule

// File: rtl/out_fault_supervisor.sv
// Output fault latch and power-good monitor. It combines the confirmed
// faults into a gate override, with overvolt first, and drives the
// open-drain power-good line. Reset acts as power-on reset. No fault
// latch clears without it.
module out_fault_supervisor
    import fg_pkg::*;
#(
    parameter int CODE_W        = 10,
    parameter int REF_CODE      = 512,
    parameter int CONFIRM_N     = 2,
    parameter int UV_PCT        = 75,
    parameter int OV_PCT        = 125,
    parameter int COLLAPSE_PCT  = 50,
    parameter int PG_IN_LO_PCT  = 93,
    parameter int PG_IN_HI_PCT  = 107,
    parameter int PG_OUT_LO_PCT = 90,
    parameter int PG_OUT_HI_PCT = 110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sense_code,
    input  logic              sample_vld,
    input  logic              ss_done,
    input  logic              ls_on,
    input  logic              oc_flag,
    output logic [1:0]        gate_mode,
    output logic              pg_drive_low
);
    logic [FLT_COUNT-1:0] raw;
    logic [FLT_COUNT-1:0] tripped;
    logic                 collapse, pg_enter, pg_leave, pg_ok, ls_released;
    gate_mode_e           mode;

    fg_level_cmp #(
        .CODE_W(CODE_W), .REF_CODE(REF_CODE), .UV_PCT(UV_PCT), .OV_PCT(OV_PCT),
        .COLLAPSE_PCT(COLLAPSE_PCT), .PG_IN_LO_PCT(PG_IN_LO_PCT),
        .PG_IN_HI_PCT(PG_IN_HI_PCT), .PG_OUT_LO_PCT(PG_OUT_LO_PCT),
        .PG_OUT_HI_PCT(PG_OUT_HI_PCT)
    ) u_cmp (
        .sense_code(sense_code), .ss_done(ss_done), .ls_on(ls_on),
        .oc_flag(oc_flag), .raw(raw), .collapse(collapse),
        .pg_enter(pg_enter), .pg_leave(pg_leave)
    );

    for (genvar f = 0; f < FLT_COUNT; f++) begin : g_confirm
        fg_trip_confirm #(.CONFIRM_N(CONFIRM_N)) u_trip (
            .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
            .raw(raw[f]), .tripped(tripped[f])
        );
    end

    // Releases the forced low side once an overvolt has collapsed the output.
    always_ff @(posedge clk) begin
        if (!rst_n) ls_released <= 1'b0;
        else if (tripped[FLT_OV] && sample_vld && collapse) ls_released <= 1'b1;
    end

    // Override selection, with overvolt ahead of the both-off faults.
    always_comb begin
        if (tripped[FLT_OV])
            mode = ls_released ? GM_BOTH_OFF : GM_LOW_ON;
        else if (tripped[FLT_UV] || tripped[FLT_OC])
            mode = GM_BOTH_OFF;
        else
            mode = GM_RUN;
    end

    fg_pgood_win u_pg (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .ss_done(ss_done),
        .fault_any(|tripped), .enter(pg_enter), .leave(pg_leave), .pg_ok(pg_ok)
    );

    // Drives the output pins.
    always_comb begin
        gate_mode    = mode;
        pg_drive_low = !pg_ok || (|tripped);
    end

    // R7
    override_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode != GM_RUN) |=> (gate_mode != GM_RUN));

    // R5
    release_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_mode) == GM_LOW_ON && gate_mode == GM_BOTH_OFF) |-> $past(sample_vld && collapse));

    // R5
    release_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_released |=> (gate_mode == GM_BOTH_OFF));
endmodule

// File: tb/out_fault_supervisor_test.sv
`timescale 1ns/1ps
module out_fault_supervisor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sense_code = 10'd0;
    logic       sample_vld = 1'b0;
    logic       ss_done = 1'b0;
    logic       ls_on = 1'b0;
    logic       oc_flag = 1'b0;
    logic [1:0] gate_mode;
    logic       pg_drive_low;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    out_fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .sense_code(sense_code), .sample_vld(sample_vld),
        .ss_done(ss_done), .ls_on(ls_on), .oc_flag(oc_flag),
        .gate_mode(gate_mode), .pg_drive_low(pg_drive_low)
    );

    task automatic chk_mode(input string req, input logic [1:0] exp);
        n_tests++;
        if (gate_mode !== exp) begin
            n_fail++;
            $display("FAIL %s gate_mode actual=%b expected=%b", req, gate_mode, exp);
        end
    endtask

    task automatic chk_pg(input string req, input logic exp);
        n_tests++;
        if (pg_drive_low !== exp) begin
            n_fail++;
            $display("FAIL %s pg_drive_low actual=%b expected=%b", req, pg_drive_low, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sample_vld = 1'b0; ss_done = 1'b0; ls_on = 1'b0;
        oc_flag = 1'b0; sense_code = 10'd512;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic smp(input int code);
        @(negedge clk);
        sense_code = 10'(code); sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_mode("R1", 2'b00);
        chk_pg("R1", 1'b1);
    endtask

    task automatic t_uv();
        do_reset();
        smp(300); smp(300); smp(300);
        chk_mode("R2 disarmed before soft-start", 2'b00);
        ss_done = 1'b1;
        smp(300); smp(300);
        chk_mode("R2 trip", 2'b01);
        chk_pg("R12 fault", 1'b1);
        smp(512); smp(512);
        chk_mode("R7 hold", 2'b01);
        do_reset();
        chk_mode("R7 cleared by reset", 2'b00);
    endtask

    task automatic t_filter();
        do_reset();
        ss_done = 1'b1;
        smp(300);
        chk_mode("R3 single sample", 2'b00);
        smp(512); smp(300);
        chk_mode("R3 interrupted", 2'b00);
        smp(300);
        chk_mode("R3 consecutive", 2'b01);
    endtask

    task automatic t_ov();
        do_reset();
        smp(700);
        chk_mode("R3 single ov", 2'b00);
        smp(700);
        chk_mode("R4 trip during soft-start", 2'b10);
        smp(400);
        chk_mode("R5 above collapse", 2'b10);
        smp(200);
        chk_mode("R5 released", 2'b01);
        smp(700); smp(700);
        chk_mode("R5 stays released", 2'b01);
    endtask

    task automatic t_oc();
        do_reset();
        ss_done = 1'b1; oc_flag = 1'b1; ls_on = 1'b0;
        smp(512); smp(512);
        chk_mode("R6 ignored when low side off", 2'b00);
        ls_on = 1'b1; smp(512);
        ls_on = 1'b0; smp(512);
        ls_on = 1'b1; smp(512);
        chk_mode("R6 sequence broken", 2'b00);
        smp(512);
        chk_mode("R6 trip", 2'b01);
    endtask

    task automatic t_priority();
        do_reset();
        ss_done = 1'b1; ls_on = 1'b1; oc_flag = 1'b1;
        smp(700); smp(700);
        chk_mode("R8 ov over oc", 2'b10);
        do_reset();
        ss_done = 1'b1;
        smp(300); smp(300);
        chk_mode("R8 uv first", 2'b01);
        smp(700); smp(700);
        chk_mode("R8 ov after uv", 2'b10);
    endtask

    task automatic t_pgood();
        do_reset();
        smp(500);
        chk_pg("R12 soft-start running", 1'b1);
        ss_done = 1'b1;
        smp(465);
        chk_pg("R10 outside entry window", 1'b1);
        smp(500);
        chk_pg("R9 good", 1'b0);
        smp(465);
        chk_pg("R10 inside exit band", 1'b0);
        smp(455);
        chk_pg("R10 lost low", 1'b1);
        chk_mode("R11 still running", 2'b00);
        smp(465);
        chk_pg("R10 no reentry at 465", 1'b1);
        smp(480);
        chk_pg("R10 reentry", 1'b0);
        smp(560);
        chk_pg("R10 high band kept", 1'b0);
        smp(570);
        chk_pg("R10 lost high", 1'b1);
        chk_mode("R11 still running high", 2'b00);
        smp(500);
        ss_done = 1'b0;
        @(negedge clk);
        chk_pg("R12 soft-start dropped", 1'b1);
    endtask

    initial begin
        t_reset();
        t_uv();
        t_filter();
        t_ov();
        t_oc();
        t_priority();
        t_pgood();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule